// File: doc/BRIEF.md
# Programmable Reloading Binary Up Counter

This block is an 8-bit synchronous binary up counter with a parallel preset bus, a count enable and an active-low terminal-count output. When the count reaches all ones, the terminal-count output goes low. That output can enable the next stage of a wider counter, or it can be routed back inside the block.

The internal feedback path is gated by a reload control input. With the reload control low, the counter runs freely and wraps from all ones to zero. With the reload control high, reaching all ones makes the next enabled clock edge load the preset value instead of incrementing. The counter then works as a divide-by-(256 − preset) circuit. A master reset clears the count at once, without waiting for a clock edge.

Top module: `reload_upcounter`

## Requirements
- R1: While `cnt_en` is 1 and no load applies, each rising clock edge adds one to `count` in plain binary.
- R2: `count` changes only on a rising clock edge (master reset excepted). A change on `load_en` or `preset` between edges leaves `count` as it was until the next edge.
- R3: While `rst` is 1, `count` is 0 and `tc_n` is 1. Raising `rst` clears `count` without any clock edge.
- R4: `tc_n` is 0 exactly when all eight bits of `count` are 1, and is 1 otherwise.
- R5: With `tc_reload` at 0 and `cnt_en` at 1, a count of 8'hFF becomes 8'h00 on the next edge.
- R6: When `load_en` is 1, the next edge copies `preset` into `count`. This holds whatever `cnt_en`, `tc_reload` and the present count are.
- R7: With `tc_reload` at 1 and `cnt_en` at 1, a count of 8'hFF is replaced by `preset` on the next edge. With a steady preset P, the count repeats with a period of 256 − P clocks: 256 for P = 0 and 1 for P = 255.
- R8: With `cnt_en` at 0 and `load_en` at 0, `count` holds its value.
- R9: With `cnt_en` at 0, a count of 8'hFF stays at 8'hFF even when `tc_reload` is 1. The automatic reload needs the count enable.
- R10: Two instances cascade into a 16-bit counter when the upper stage's `cnt_en` is driven by the lower stage's `cnt_en` AND NOT `tc_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous master reset, active high |
| cnt_en | input | 1 | Count enable, active high |
| load_en | input | 1 | Parallel load enable, active high |
| tc_reload | input | 1 | Enables reload of the preset at terminal count |
| preset | input | 8 | Parallel preset value |
| count | output | 8 | Current count |
| tc_n | output | 1 | Terminal count, low when the count is all ones |

## Verification
The counter is tried with a straight run from zero, a free-running wrap through all ones, and a stalled enable. These show whether the increment path, the wrap path and the hold path are kept apart. Reload runs with presets 0, 17, 200, 254 and 255 are each checked cycle by cycle over two full periods, which separates an off-by-one reload from a correct one at both extremes. Loads are tried at all ones and against an active count enable to confirm the priority. A cascaded pair run across several carries shows whether `tc_n` is low for exactly the right cycle.

// File: rtl/rupc_pkg.sv
package rupc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_INC    = 2'd1,
    ACT_LOAD   = 2'd2,
    ACT_RELOAD = 2'd3
  } ctr_act_e;

endpackage

// File: rtl/rupc_term_detect.sv
module rupc_term_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             at_term,
  output logic             term_n
);

  function automatic logic is_full(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  assign at_term = is_full(value);
  assign term_n  = ~at_term;

endmodule

// File: rtl/rupc_action_decode.sv
module rupc_action_decode
  import rupc_pkg::*;
(
  input  logic     load_en,
  input  logic     cnt_en,
  input  logic     tc_reload,
  input  logic     at_term,
  output ctr_act_e act,
  output logic     ext_load,
  output logic     auto_reload,
  output logic     inc_fire
);

  // An explicit load wins. The automatic reload needs the count enable
  // and the reload control, and the count must sit at terminal.
  assign ext_load    = load_en;
  assign auto_reload = ~load_en & cnt_en & tc_reload & at_term;
  assign inc_fire    = ~load_en & cnt_en & ~auto_reload;

  always_comb begin
    if (ext_load)         act = ACT_LOAD;
    else if (auto_reload) act = ACT_RELOAD;
    else if (inc_fire)    act = ACT_INC;
    else                  act = ACT_HOLD;
  end

endmodule

// File: rtl/rupc_state_reg.sv
module rupc_state_reg
  import rupc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctr_act_e         act,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] value
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  function automatic logic [WIDTH-1:0] bump(input logic [WIDTH-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [WIDTH-1:0] next_of(
    input ctr_act_e         a,
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] pre
  );
    case (a)
      ACT_LOAD, ACT_RELOAD: return pre;
      ACT_INC:              return bump(cur);
      default:              return cur;
    endcase
  endfunction

  logic [WIDTH-1:0] value_nx;
  assign value_nx = next_of(act, value, preset);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) value <= '0;
    else     value <= value_nx;
  end

endmodule

// File: rtl/reload_upcounter.sv
module reload_upcounter
  import rupc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             load_en,
  input  logic             tc_reload,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             tc_n
);

  ctr_act_e         act;
  logic             at_term;
  logic             ext_load;
  logic             auto_reload;
  logic             inc_fire;
  logic [WIDTH-1:0] value;

  rupc_term_detect #(.WIDTH(WIDTH)) u_term (
    .value   (value),
    .at_term (at_term),
    .term_n  (tc_n)
  );

  rupc_action_decode u_dec (
    .load_en     (load_en),
    .cnt_en      (cnt_en),
    .tc_reload   (tc_reload),
    .at_term     (at_term),
    .act         (act),
    .ext_load    (ext_load),
    .auto_reload (auto_reload),
    .inc_fire    (inc_fire)
  );

  rupc_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .preset (preset),
    .value  (value)
  );

  assign count = value;

endmodule

// File: rtl/reload_upcounter_chk.sv
module reload_upcounter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             load_en,
  input logic             tc_reload,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             tc_n,
  input logic             auto_reload,
  input logic             inc_fire
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (count == '0 && tc_n));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc_fire |=> count == WIDTH'($past(count) + 1'b1));

  // R6
  ext_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> count == $past(preset));

  // R7
  auto_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && tc_reload && !tc_n && !load_en) |=> count == $past(preset));

  // R5
  free_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !tc_reload && !load_en && count == FULL) |=> count == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !load_en) |=> $stable(count));

  // R9
  no_stall_reload_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> !auto_reload);

  // R4
  term_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (count == FULL) |-> !tc_n);

endmodule

bind reload_upcounter reload_upcounter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_en      (cnt_en),
  .load_en     (load_en),
  .tc_reload   (tc_reload),
  .preset      (preset),
  .count       (count),
  .tc_n        (tc_n),
  .auto_reload (auto_reload),
  .inc_fire    (inc_fire)
);

// File: tb/reload_upcounter_test.sv
module reload_upcounter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       load_en = 1'b0;
  logic       tc_reload = 1'b0;
  logic [7:0] preset = 8'h00;
  logic [7:0] count;
  logic       tc_n;

  logic [7:0] hi_count;
  logic       hi_tc_n;
  logic       hi_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  reload_upcounter uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_en(load_en),
    .tc_reload(tc_reload), .preset(preset), .count(count), .tc_n(tc_n)
  );

  // R10: upper stage of a cascaded pair
  assign hi_en = cnt_en & ~tc_n;
  reload_upcounter uut_hi (
    .clk(clk), .rst(rst), .cnt_en(hi_en), .load_en(load_en),
    .tc_reload(1'b0), .preset(8'h00), .count(hi_count), .tc_n(hi_tc_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [7:0] v);
    load_en = 1'b1;
    preset  = v;
    tick();
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    chk(count == 8'h00, "R3 reset count", count, 0);
    chk(tc_n == 1'b1, "R3 reset tc_n", tc_n, 1);
    rst = 1'b0;
    do_load(8'hAA);
    chk(count == 8'hAA, "R6 load before async reset", count, 8'hAA);
    #3 rst = 1'b1;
    #1 chk(count == 8'h00, "R3 async clear without edge", count, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_count();
    cnt_en = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      tick();
      chk(count == 8'(i), "R1 increment", count, i);
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_sync();
    // R2: a mid-cycle load request must wait for the edge
    #2 load_en = 1'b1;
    preset = 8'h5C;
    #3 chk(count == 8'h0A, "R2 no change between edges", count, 8'h0A);
    @(negedge clk);
    load_en = 1'b0;
    chk(count == 8'h5C, "R2 change at edge", count, 8'h5C);
  endtask

  task automatic t_load_priority();
    cnt_en = 1'b1;
    do_load(8'hA5);
    chk(count == 8'hA5, "R6 load beats count enable", count, 8'hA5);
    do_load(8'hFF);
    tc_reload = 1'b1;
    preset = 8'h40;
    do_load(8'h3C);
    chk(count == 8'h3C, "R6 load beats reload at FF", count, 8'h3C);
    tc_reload = 1'b0;
    cnt_en = 1'b0;
  endtask

  task automatic t_wrap();
    do_load(8'hFD);
    cnt_en = 1'b1;
    tc_reload = 1'b0;
    chk(tc_n == 1'b1, "R4 tc_n high at FD", tc_n, 1);
    tick();
    chk(count == 8'hFE, "R1 FD to FE", count, 8'hFE);
    chk(tc_n == 1'b1, "R4 tc_n high at FE", tc_n, 1);
    tick();
    chk(count == 8'hFF, "R1 FE to FF", count, 8'hFF);
    chk(tc_n == 1'b0, "R4 tc_n low at FF", tc_n, 0);
    tick();
    chk(count == 8'h00, "R5 wrap to zero", count, 0);
    chk(tc_n == 1'b1, "R4 tc_n high after wrap", tc_n, 1);
    cnt_en = 1'b0;
  endtask

  task automatic t_hold();
    do_load(8'h77);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(count == 8'h77, "R8 hold", count, 8'h77);
    end
  endtask

  task automatic t_stall_full();
    do_load(8'hFF);
    preset = 8'h12;
    tc_reload = 1'b1;
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(count == 8'hFF, "R9 stalled at FF", count, 8'hFF);
    end
    tc_reload = 1'b0;
  endtask

  task automatic t_reload(input int p);
    int per;
    int exp;
    per = 256 - p;
    do_load(8'(p));
    chk(count == 8'(p), "R7 reload start", count, p);
    tc_reload = 1'b1;
    cnt_en = 1'b1;
    for (int k = 1; k <= 2 * per; k++) begin
      tick();
      exp = p + (k % per);
      chk(count == 8'(exp), "R7 reload sequence", count, exp);
      chk(tc_n == (exp != 255), "R4 tc_n in reload run", tc_n, (exp != 255));
    end
    cnt_en = 1'b0;
    tc_reload = 1'b0;
  endtask

  task automatic t_cascade();
    int exp;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk({hi_count, count} == 16'h0000, "R10 cascade reset", {hi_count, count}, 0);
    cnt_en = 1'b1;
    for (int k = 1; k <= 700; k++) begin
      tick();
      exp = k;
      chk({hi_count, count} == 16'(exp), "R10 cascade value", {hi_count, count}, exp);
    end
    cnt_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_sync();
    t_load_priority();
    t_wrap();
    t_hold();
    t_stall_full();
    t_reload(0);
    t_reload(17);
    t_reload(200);
    t_reload(254);
    t_reload(255);
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule